// File: doc/BRIEF.md
# Floating-Point Pipeline Reservation Scoreboard

This block decides, cycle by cycle, whether a new floating-point or integer-multiply operation may enter a pipeline whose stages are held for several cycles at a time. The pipeline has four shared stages (S0, S1, S2 and a long-occupancy divide stage S3) and two interchangeable multiply stages (MA and MB). Each operation class occupies a fixed set of these stages in each cycle after issue. The scoreboard records those future claims in a window of busy vectors. The window advances by one slot every clock.

A request names an operation class and raises `req_valid`. The scoreboard lines up the class's usage pattern from the next cycle onward against the window. The request is accepted only if no stage would be claimed twice. The multiply stages must also never be busy in the same cycle as S1. An accepted pattern is merged into the window at the clock edge. A refused request sees `req_stall`. The requester keeps the same class code and retries every cycle until the request is accepted. For an integer multiply, the scoreboard takes copy MA when MA is free in all three cycles the multiply needs. Otherwise it takes MB.

The window depth is a parameter. It must hold at least 24 slots so that the longest pattern fits.

Top module: `fpu_rsv_sb`

## Requirements
- R1: While `rst_n` is low at a clock edge, all reservations are cleared, so `busy_now` reads 0 in the following cycle. `req_accept` stays 0 while `rst_n` is low.
- R2: `req_accept` is 1 exactly when `req_valid` is 1 and the class pattern fits the window. `req_stall` equals `req_valid` and not `req_accept`. A cycle with `req_valid` low reserves nothing.
- R3: Class code 0 (single-precision add/compare) claims S0+S1 in the cycle after acceptance and S2 in the cycle after that.
- R4: Class code 1 (single-precision divide) claims S0+S1+S3, then S2+S3, then S3 alone for 7 cycles, then S1+S3, then S2. Class code 2 (square root) is the same with 6 cycles of S3 alone.
- R5: Class code 3 (double-precision divide) claims S0+S1+S3, then S1+S2+S3, then S2+S3, then S3 alone for 16 cycles, then S1+S3, then S1+S2+S3 twice, then S2.
- R6: Class code 4 (double-precision add/multiply) claims S0+S1, then S1+S2 for 5 cycles, then S2. Class code 5 (double-precision conversion) claims S0+S1, then S1+S2, then S2.
- R7: Class code 6 (integer multiply) claims one multiply copy for 3 cycles and then S2. MA is chosen when it is free in all three cycles, otherwise MB. The request stalls when neither copy is free.
- R8: A pattern that needs S1 in a cycle where either multiply copy is reserved is refused. A pattern that needs a multiply copy in a cycle where S1 is reserved is also refused.
- R9: Class code 7 (status-register load) claims nothing in the first cycle after acceptance and S1 in each of the next three cycles.
- R10: `busy_now` shows the stages reserved in the current cycle, with bit 0 = S0, bit 1 = S1, bit 2 = S2, bit 3 = S3, bit 4 = MA and bit 5 = MB. Reservations from overlapping accepted operations combine by OR and advance one slot per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_class | input | 3 | Operation class code of the request |
| req_accept | output | 1 | Request fits and is reserved at this edge |
| req_stall | output | 1 | Request present but refused this cycle |
| busy_now | output | 6 | Stages reserved in the current cycle |

## Verification
The bench builds the block with a depth of 24, the smallest window that holds the double-precision divide. With that depth, the last stage claim of that pattern lands in the final window slot, so an off-by-one in the shift or in the comparison offset shows up directly. The default depth of 32 only adds empty tail slots. Those slots are exercised by elaboration alone.

// File: rtl/fpu_rsv_pkg.sv
// Shared definitions for the reservation scoreboard: stage indices, the
// operation class codes and the per-slot usage function for each class.
// Assumes slot 0 of a pattern is the cycle after the request is accepted.
package fpu_rsv_pkg;

    localparam int NRES    = 6;
    localparam int RS_S0   = 0;
    localparam int RS_S1   = 1;
    localparam int RS_S2   = 2;
    localparam int RS_S3   = 3;
    localparam int RS_MA   = 4;
    localparam int RS_MB   = 5;
    localparam int PAT_LEN = 23;

    typedef logic [NRES-1:0] res_t;

    typedef enum logic [2:0] {
        OP_SADD   = 3'd0,
        OP_SDIV   = 3'd1,
        OP_SSQRT  = 3'd2,
        OP_DDIV   = 3'd3,
        OP_DARITH = 3'd4,
        OP_DCONV  = 3'd5,
        OP_IMUL   = 3'd6,
        OP_CSRLD  = 3'd7
    } op_e;

    localparam res_t U_S0 = 6'b000001;
    localparam res_t U_S1 = 6'b000010;
    localparam res_t U_S2 = 6'b000100;
    localparam res_t U_S3 = 6'b001000;
    localparam res_t U_MA = 6'b010000;
    localparam res_t U_MB = 6'b100000;

    // Stages claimed by class op in pattern slot j; alt picks multiply copy MB.
    function automatic res_t slot_use(op_e op, int j, logic alt);
        res_t u;
        u = '0;
        case (op)
            OP_SADD: begin
                if (j == 0)      u = U_S0 | U_S1;
                else if (j == 1) u = U_S2;
            end
            OP_SDIV: begin
                if (j == 0)                u = U_S0 | U_S1 | U_S3;
                else if (j == 1)           u = U_S2 | U_S3;
                else if (j >= 2 && j <= 8) u = U_S3;
                else if (j == 9)           u = U_S1 | U_S3;
                else if (j == 10)          u = U_S2;
            end
            OP_SSQRT: begin
                if (j == 0)                u = U_S0 | U_S1 | U_S3;
                else if (j == 1)           u = U_S2 | U_S3;
                else if (j >= 2 && j <= 7) u = U_S3;
                else if (j == 8)           u = U_S1 | U_S3;
                else if (j == 9)           u = U_S2;
            end
            OP_DDIV: begin
                if (j == 0)                 u = U_S0 | U_S1 | U_S3;
                else if (j == 1)            u = U_S1 | U_S2 | U_S3;
                else if (j == 2)            u = U_S2 | U_S3;
                else if (j >= 3 && j <= 18) u = U_S3;
                else if (j == 19)           u = U_S1 | U_S3;
                else if (j == 20 || j == 21) u = U_S1 | U_S2 | U_S3;
                else if (j == 22)           u = U_S2;
            end
            OP_DARITH: begin
                if (j == 0)                u = U_S0 | U_S1;
                else if (j >= 1 && j <= 5) u = U_S1 | U_S2;
                else if (j == 6)           u = U_S2;
            end
            OP_DCONV: begin
                if (j == 0)      u = U_S0 | U_S1;
                else if (j == 1) u = U_S1 | U_S2;
                else if (j == 2) u = U_S2;
            end
            OP_IMUL: begin
                if (j >= 0 && j <= 2) u = alt ? U_MB : U_MA;
                else if (j == 3)      u = U_S2;
            end
            OP_CSRLD: begin
                if (j >= 1 && j <= 3) u = U_S1;
            end
            default: u = '0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/fpu_rsv_pattern.sv
// Expands an operation class into its slot-by-slot stage usage.
// Pure combinational; ALT selects the second multiply copy for multiplies.
module fpu_rsv_pattern
    import fpu_rsv_pkg::*;
#(
    parameter int NSLOT = 31
) (
    input  logic [2:0]                 op_code,
    input  logic                       alt,
    output logic [NSLOT-1:0][NRES-1:0] pat
);

    // One usage lookup per slot of the window.
    for (genvar j = 0; j < NSLOT; j++) begin : g_slot
        assign pat[j] = slot_use(op_e'(op_code), j, alt);
    end

endmodule

// File: rtl/fpu_rsv_clash.sv
// Compares a candidate pattern with the future busy slots. Reports a clash
// on any doubly claimed stage, or on S1 meeting a multiply copy in one slot.
module fpu_rsv_clash
    import fpu_rsv_pkg::*;
#(
    parameter int NSLOT = 31
) (
    input  logic [NSLOT-1:0][NRES-1:0] pat,
    input  logic [NSLOT-1:0][NRES-1:0] fut,
    output logic                       clash
);

    logic [NSLOT-1:0] slot_hit;

    // Per-slot overlap and S1/multiply exclusion test.
    for (genvar j = 0; j < NSLOT; j++) begin : g_slot
        logic same_hit;
        logic excl_hit;
        assign same_hit = |(pat[j] & fut[j]);
        assign excl_hit = (pat[j][RS_S1] & (fut[j][RS_MA] | fut[j][RS_MB]))
                        | ((pat[j][RS_MA] | pat[j][RS_MB]) & fut[j][RS_S1]);
        assign slot_hit[j] = same_hit | excl_hit;
    end

    assign clash = |slot_hit;

endmodule

// File: rtl/fpu_rsv_window.sv
// Holds the busy vectors for the current cycle (slot 0) and DEPTH-1
// future cycles. Each clock it advances one slot and ORs in a new pattern.
module fpu_rsv_window
    import fpu_rsv_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int NSLOT = DEPTH - 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [NSLOT-1:0][NRES-1:0] add,
    output logic [DEPTH-1:0][NRES-1:0] win
);

    logic [DEPTH-1:0][NRES-1:0] win_d;

    // Next value of each slot: the slot above it plus any new claim.
    for (genvar k = 0; k < DEPTH; k++) begin : g_next
        if (k == DEPTH - 1) begin : g_top
            assign win_d[k] = '0;
        end else begin : g_mid
            assign win_d[k] = win[k+1] | (load ? add[k] : '0);
        end
    end

    // Window register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) win <= '0;
        else        win <= win_d;
    end

endmodule

// File: rtl/fpu_rsv_sb.sv
// Top of the reservation scoreboard. Tries the request's pattern with
// multiply copy MA and with MB. Accepts when either fits (MA first) and
// merges the chosen pattern into the window. Assumes the requester holds
// its class code while stalled.
module fpu_rsv_sb
    import fpu_rsv_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int NSLOT = DEPTH - 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_class,
    output logic       req_accept,
    output logic       req_stall,
    output logic [5:0] busy_now
);

    logic [DEPTH-1:0][NRES-1:0] win;
    logic [NSLOT-1:0][NRES-1:0] fut;
    logic [NSLOT-1:0][NRES-1:0] pat_a;
    logic [NSLOT-1:0][NRES-1:0] pat_b;
    logic [NSLOT-1:0][NRES-1:0] pat_sel;
    logic                       clash_a;
    logic                       clash_b;

    assign fut = win[DEPTH-1:1];

    fpu_rsv_pattern #(.NSLOT(NSLOT)) u_pat_a (
        .op_code (req_class),
        .alt     (1'b0),
        .pat     (pat_a)
    );

    fpu_rsv_pattern #(.NSLOT(NSLOT)) u_pat_b (
        .op_code (req_class),
        .alt     (1'b1),
        .pat     (pat_b)
    );

    fpu_rsv_clash #(.NSLOT(NSLOT)) u_clash_a (
        .pat   (pat_a),
        .fut   (fut),
        .clash (clash_a)
    );

    fpu_rsv_clash #(.NSLOT(NSLOT)) u_clash_b (
        .pat   (pat_b),
        .fut   (fut),
        .clash (clash_b)
    );

    // Accept decision and copy choice, MA preferred.
    always_comb begin
        req_accept = rst_n & req_valid & (~clash_a | ~clash_b);
        req_stall  = req_valid & ~req_accept;
        pat_sel    = clash_a ? pat_b : pat_a;
    end

    fpu_rsv_window #(.DEPTH(DEPTH)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (req_accept),
        .add   (pat_sel),
        .win   (win)
    );

    assign busy_now = win[0];

endmodule

// File: rtl/fpu_rsv_sb_chk.sv
// Property checker for the scoreboard, bound to every instance of the top.
// Observes ports only.
module fpu_rsv_sb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_class,
    input logic       req_accept,
    input logic       req_stall,
    input logic [5:0] busy_now
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> busy_now == 6'b0); // R1

    AST_NO_ACCEPT_IN_RESET: assert property (@(posedge clk)
        !rst_n |-> !req_accept); // R1

    AST_STALL_OR_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_accept ^ req_stall)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!req_accept && !req_stall)); // R2

    AST_SADD_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_class == 3'd0) |=> (busy_now[0] && busy_now[1]) ##1 busy_now[2]); // R3

    AST_SDIV_HOLDS_S3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_class == 3'd1) |=> busy_now[3] ##1 busy_now[3]); // R4

    AST_MUL_TAKES_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_class == 3'd6) |=> (busy_now[4] || busy_now[5])); // R7

    AST_S1_EXCLUDES_MUL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_now[1] |-> (!busy_now[4] && !busy_now[5])); // R8

    AST_CSRLD_S1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_class == 3'd7) |-> ##2 busy_now[1]); // R9

endmodule

bind fpu_rsv_sb fpu_rsv_sb_chk u_chk (.*);

// File: tb/fpu_rsv_sb_tb.sv
module fpu_rsv_sb_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [2:0] req_class;
    logic       req_accept;
    logic       req_stall;
    logic [5:0] busy_now;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fpu_rsv_sb #(.DEPTH(24)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_class  (req_class),
        .req_accept (req_accept),
        .req_stall  (req_stall),
        .busy_now   (busy_now)
    );

    // Row layout: {tag[3:0], valid, class[2:0], accept, busy[5:0]}.
    localparam int NVEC = 49;
    localparam logic [14:0] VEC [NVEC] = '{
        {4'd3, 1'b1, 3'd0, 1'b1, 6'b000000},
        {4'd3, 1'b1, 3'd0, 1'b1, 6'b000011},
        {4'd2, 1'b0, 3'd0, 1'b0, 6'b000111},
        {4'd6, 1'b1, 3'd4, 1'b1, 6'b000100},
        {4'd6, 1'b1, 3'd0, 1'b0, 6'b000011},
        {4'd6, 1'b1, 3'd0, 1'b0, 6'b000110},
        {4'd6, 1'b1, 3'd0, 1'b0, 6'b000110},
        {4'd6, 1'b1, 3'd0, 1'b0, 6'b000110},
        {4'd6, 1'b1, 3'd0, 1'b0, 6'b000110},
        {4'd6, 1'b1, 3'd0, 1'b1, 6'b000110},
        {4'd7, 1'b1, 3'd6, 1'b1, 6'b000111},
        {4'd7, 1'b1, 3'd6, 1'b1, 6'b010100},
        {4'd7, 1'b1, 3'd6, 1'b0, 6'b110000},
        {4'd7, 1'b1, 3'd6, 1'b1, 6'b110000},
        {4'd8, 1'b1, 3'd0, 1'b0, 6'b110100},
        {4'd9, 1'b1, 3'd7, 1'b1, 6'b010100},
        {4'd8, 1'b1, 3'd6, 1'b0, 6'b010000},
        {4'd8, 1'b1, 3'd6, 1'b0, 6'b000110},
        {4'd8, 1'b1, 3'd6, 1'b0, 6'b000010},
        {4'd7, 1'b1, 3'd6, 1'b1, 6'b000010},
        {4'd10, 1'b0, 3'd0, 1'b0, 6'b010000},
        {4'd10, 1'b0, 3'd0, 1'b0, 6'b010000},
        {4'd10, 1'b0, 3'd0, 1'b0, 6'b010000},
        {4'd10, 1'b0, 3'd0, 1'b0, 6'b000100},
        {4'd4, 1'b1, 3'd1, 1'b1, 6'b000000},
        {4'd4, 1'b1, 3'd2, 1'b0, 6'b001011},
        {4'd4, 1'b1, 3'd0, 1'b1, 6'b001100},
        {4'd4, 1'b1, 3'd0, 1'b1, 6'b001011},
        {4'd4, 1'b1, 3'd2, 1'b0, 6'b001111},
        {4'd4, 1'b0, 3'd0, 1'b0, 6'b001100},
        {4'd4, 1'b0, 3'd0, 1'b0, 6'b001000},
        {4'd4, 1'b0, 3'd0, 1'b0, 6'b001000},
        {4'd4, 1'b0, 3'd0, 1'b0, 6'b001000},
        {4'd4, 1'b1, 3'd2, 1'b0, 6'b001000},
        {4'd4, 1'b1, 3'd2, 1'b1, 6'b001010},
        {4'd6, 1'b1, 3'd5, 1'b1, 6'b001111},
        {4'd6, 1'b0, 3'd0, 1'b0, 6'b001111},
        {4'd6, 1'b0, 3'd0, 1'b0, 6'b001110},
        {4'd6, 1'b0, 3'd0, 1'b0, 6'b001100},
        {4'd4, 1'b0, 3'd0, 1'b0, 6'b001000},
        {4'd4, 1'b0, 3'd0, 1'b0, 6'b001000},
        {4'd4, 1'b0, 3'd0, 1'b0, 6'b001000},
        {4'd4, 1'b0, 3'd0, 1'b0, 6'b001000},
        {4'd4, 1'b0, 3'd0, 1'b0, 6'b001010},
        {4'd4, 1'b0, 3'd0, 1'b0, 6'b000100},
        {4'd5, 1'b1, 3'd3, 1'b1, 6'b000000},
        {4'd5, 1'b1, 3'd3, 1'b0, 6'b001011},
        {4'd5, 1'b0, 3'd0, 1'b0, 6'b001110},
        {4'd5, 1'b0, 3'd0, 1'b0, 6'b001100}
    };

    function automatic string tag(input int n);
        case (n)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one request at the falling edge and sample just after it.
    task automatic step(input logic v, input logic [2:0] c);
        @(negedge clk);
        req_valid = v;
        req_class = c;
        #1;
    endtask

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_class = 3'd0;

        // R1: reset state, and no acceptance while reset is low
        step(1'b1, 3'd0);
        step(1'b1, 3'd0);
        chk("R1", "busy in reset", 32'(busy_now), 32'h0);
        chk("R1", "accept in reset", 32'(req_accept), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        req_valid = 1'b0;
        // Table cycles c0..c48; the first row is driven in the next cycle.
        @(posedge clk);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][10], VEC[i][9:7]);
            chk(tag(int'(VEC[i][14:11])), $sformatf("accept row %0d", i),
                32'(req_accept), 32'(VEC[i][6]));
            chk("R2", $sformatf("stall row %0d", i),
                32'(req_stall), 32'(VEC[i][10] & ~VEC[i][6]));
            chk(tag(int'(VEC[i][14:11])), $sformatf("busy row %0d", i),
                32'(busy_now), 32'(VEC[i][5:0]));
        end

        // R5: long S3 hold of the double divide refuses a single divide
        // until its final claim slot has passed (cycles c49..c67).
        for (int c = 49; c <= 67; c++) begin
            logic [5:0] exp_busy;
            step(1'b1, 3'd1);
            if (c <= 64)      exp_busy = 6'b001000;
            else if (c == 65) exp_busy = 6'b001010;
            else              exp_busy = 6'b001110;
            chk("R5", $sformatf("divide hold busy c%0d", c), 32'(busy_now), 32'(exp_busy));
            chk("R5", $sformatf("divide hold accept c%0d", c),
                32'(req_accept), 32'(c == 67));
        end

        // R10: tail of the double divide ORed with head of the single divide
        step(1'b0, 3'd0);
        chk("R10", "merged busy", 32'(busy_now), 32'h0f);

        // R1: reset in mid-run clears everything and blocks acceptance
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b1;
        req_class = 3'd0;
        #1;
        chk("R1", "accept while reset", 32'(req_accept), 32'h0);
        step(1'b1, 3'd3);
        rst_n = 1'b1;
        #0;
        chk("R1", "busy after reset", 32'(busy_now), 32'h0);
        chk("R5", "divide after reset", 32'(req_accept), 32'h1);
        step(1'b0, 3'd0);
        chk("R5", "divide first slot", 32'(busy_now), 32'h0b);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule